// File: doc/BRIEF.md
# Wide-to-narrow register bridge

This block lets a 32-bit memory-mapped bus master with a request/acknowledge handshake (classic Wishbone style: the master holds its request steady until it sees acknowledge) reach a bank of 8-bit peripheral registers. A build parameter picks between two address layouts. In the packed layout, each byte lane of a wide word is its own narrow register, and one wide access becomes a short sequence of byte transactions. In the spread layout, every narrow register takes up a whole wide word, and one wide access becomes exactly one narrow transaction. The spread layout needs no lane sequencing.

A small window of narrow addresses is served inside the bridge and is not forwarded to the narrow bus. It holds one multi-byte register, reached through a parallel value/update port. The bridge keeps a read shadow and a write shadow for it. A multi-byte value read or written byte by byte, from the lowest byte to the highest with no other access in between, is therefore seen or changed as a whole. Narrow addresses at or above the populated range have nothing behind them.

Top module: `reg_bridge`

## Requirements
- R1: With SPARSE=1, the narrow address is the byte address shifted right by two. Write data is taken from up_wdata[7:0]. Read data is returned in up_rdata[7:0] with bits [31:8] zero. Each access makes exactly one narrow transaction.
- R2: With SPARSE=0, byte lane L (bits 8L+7..8L) of the word at byte address A maps to narrow address 4*(A>>2)+L, in both the write and the read direction.
- R3: With SPARSE=0, only lanes whose up_sel bit is set make narrow transactions, and they are issued in ascending lane order. Read lanes that are not selected return zero.
- R4: Each access is acknowledged exactly once, with up_ack high for a single cycle. It rises two cycles after the request is first seen in spread mode, and five cycles after it in packed mode.
- R5: A narrow transaction lasts one cycle, with at most one of nr_rd and nr_wr high. Read data on nr_rdata is taken in the cycle after the address.
- R6: A narrow address at or above NUM_REGS (16 by default) is still acknowledged. It reads as zero, makes no narrow transaction and changes nothing.
- R7: Narrow addresses ATOM_BASE..ATOM_BASE+ATOM_BYTES-1 (8..11 by default, with index 0 as the lowest byte) form the multi-byte register. Reading index 0 latches the whole of at_rdata into a shadow. Reads of indices 1, 2, ... that follow in order, with no access in between, return the latched bytes.
- R8: Writes to the lower indices of the multi-byte register are held in a shadow. A write of the top index that completes an in-order write sequence raises at_we for one cycle, in the cycle after that byte is issued, with at_wdata holding all the bytes. No other write changes the register.
- R9: Any other byte access, or a change between read and write, breaks a sequence. After that, a read of a non-zero index returns the live byte from at_rdata, and a write of the top index is ignored.
- R10: During and right after reset, up_ack, nr_rd, nr_wr and at_we are low, and no narrow transaction happens without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Wide request, held until acknowledged |
| up_we | input | 1 | Wide write enable |
| up_addr | input | UA_W | Wide byte address |
| up_sel | input | 4 | Byte-lane selects (packed layout only) |
| up_wdata | input | 32 | Wide write data |
| up_ack | output | 1 | One-cycle acknowledge |
| up_rdata | output | 32 | Wide read data, valid while up_ack is high |
| nr_rd | output | 1 | Narrow read strobe |
| nr_wr | output | 1 | Narrow write strobe |
| nr_addr | output | NA_W | Narrow register address |
| nr_wdata | output | 8 | Narrow write data |
| nr_rdata | input | 8 | Narrow read data, one cycle after the address |
| at_rdata | input | 8*ATOM_BYTES | Live value of the multi-byte register |
| at_we | output | 1 | One-cycle update strobe for the multi-byte register |
| at_wdata | output | 8*ATOM_BYTES | New value of the multi-byte register |

## Verification
The assertions assume a master that keeps up_req and its address, data and selects steady from the request until acknowledge, and that drops or changes the request only in the acknowledge cycle. They also assume the narrow side answers a read in the next cycle. The bench drives each access from a task at the falling edge. It holds all fields until it samples up_ack, and it releases the request in that same cycle. Its narrow-bus and multi-byte register models answer with exactly one cycle of latency. The bench changes the multi-byte register's live value only between accesses, which is how it exposes the shadowed and the live bytes.

// File: rtl/reg_bridge.sv
module reg_bridge #(
  parameter bit SPARSE     = 1'b0,
  parameter int UA_W       = 16,
  parameter int NA_W       = 6,
  parameter int NUM_REGS   = 16,
  parameter int ATOM_BASE  = 8,
  parameter int ATOM_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    up_req,
  input  logic                    up_we,
  input  logic [UA_W-1:0]         up_addr,
  input  logic [3:0]              up_sel,
  input  logic [31:0]             up_wdata,
  output logic                    up_ack,
  output logic [31:0]             up_rdata,
  output logic                    nr_rd,
  output logic                    nr_wr,
  output logic [NA_W-1:0]         nr_addr,
  output logic [7:0]              nr_wdata,
  input  logic [7:0]              nr_rdata,
  input  logic [ATOM_BYTES*8-1:0] at_rdata,
  output logic                    at_we,
  output logic [ATOM_BYTES*8-1:0] at_wdata
);

  localparam int LAST = SPARSE ? 0 : 3;
  localparam int AW   = ATOM_BYTES * 8;
  localparam int IX_W = $clog2(ATOM_BYTES);
  localparam logic [UA_W-1:0] WIN_LO  = UA_W'(ATOM_BASE);
  localparam logic [UA_W-1:0] WIN_HI  = UA_W'(ATOM_BASE + ATOM_BYTES);
  localparam logic [UA_W-1:0] REG_TOP = UA_W'(NUM_REGS);
  localparam logic [IX_W-1:0] TOP     = IX_W'(ATOM_BYTES - 1);

  logic [2:0]      step;
  logic [1:0]      lane;
  logic [UA_W-1:0] naddr;
  logic            issuing, lane_on, act, in_win, on_bus, in_seq, commit;
  logic [IX_W-1:0] widx;
  logic [7:0]      wbyte, win_byte;

  logic [31:0]     rbuf;
  logic            cap_v, cap_nr;
  logic [1:0]      cap_lane;
  logic [7:0]      cap_byte;

  logic            seq_ok, seq_wr;
  logic [IX_W-1:0] seq_nx;
  logic [AW-1:0]   rsh, wsh, at_wd_q;
  logic            at_we_q;
  logic            unused_bits;

  assign lane    = step[1:0];
  assign naddr   = SPARSE ? (up_addr >> 2) : {up_addr[UA_W-1:2], lane};
  assign issuing = up_req && !up_ack && (step <= 3'(LAST));
  assign lane_on = SPARSE ? 1'b1 : up_sel[lane];
  assign act     = issuing && lane_on;
  assign in_win  = (naddr >= WIN_LO) && (naddr < WIN_HI);
  assign on_bus  = (naddr < REG_TOP) && !in_win;
  assign widx    = IX_W'(naddr - WIN_LO);
  assign wbyte   = SPARSE ? up_wdata[7:0] : up_wdata[8*lane +: 8];

  assign in_seq  = seq_ok && (seq_nx == widx) && (seq_wr == up_we) && (widx != '0);
  assign commit  = act && in_win && up_we && (widx == TOP) && in_seq;

  always_comb begin
    if (widx == '0)  win_byte = at_rdata[7:0];
    else if (in_seq) win_byte = rsh[8*widx +: 8];
    else             win_byte = at_rdata[8*widx +: 8];
  end

  assign nr_rd    = act && on_bus && !up_we;
  assign nr_wr    = act && on_bus && up_we;
  assign nr_addr  = naddr[NA_W-1:0];
  assign nr_wdata = wbyte;
  assign up_rdata = rbuf;
  assign at_we    = at_we_q;
  assign at_wdata = at_wd_q;
  assign unused_bits = ^{up_addr[1:0], up_sel, wsh[AW-1:AW-8], rsh[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= '0;
      up_ack <= 1'b0;
    end else if (up_ack) begin
      up_ack <= 1'b0;
      step   <= '0;
    end else if (up_req) begin
      if (step == 3'(LAST + 1)) up_ack <= 1'b1;
      else                      step   <= step + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf     <= '0;
      cap_v    <= 1'b0;
      cap_nr   <= 1'b0;
      cap_lane <= '0;
      cap_byte <= '0;
    end else begin
      cap_v    <= act;
      cap_nr   <= nr_rd;
      cap_lane <= lane;
      cap_byte <= (act && in_win && !up_we) ? win_byte : 8'h00;
      if (issuing && step == '0) rbuf <= '0;
      if (cap_v) rbuf[8*cap_lane +: 8] <= cap_nr ? nr_rdata : cap_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_ok  <= 1'b0;
      seq_wr  <= 1'b0;
      seq_nx  <= '0;
      rsh     <= '0;
      wsh     <= '0;
      at_we_q <= 1'b0;
      at_wd_q <= '0;
    end else begin
      at_we_q <= commit;
      if (commit) at_wd_q <= {wbyte, wsh[AW-9:0]};
      if (act) begin
        if (in_win && widx == '0) begin
          seq_ok <= 1'b1;
          seq_nx <= IX_W'(1);
          seq_wr <= up_we;
          if (!up_we) rsh <= at_rdata;
        end else if (in_win && in_seq && widx != TOP) begin
          seq_nx <= widx + 1'b1;
        end else begin
          seq_ok <= 1'b0;
        end
        if (in_win && up_we && widx != TOP) wsh[8*widx +: 8] <= wbyte;
      end
    end
  end

endmodule

// File: rtl/reg_bridge_chk.sv
module reg_bridge_chk #(
  parameter int NA_W       = 6,
  parameter int NUM_REGS   = 16,
  parameter int ATOM_BASE  = 8,
  parameter int ATOM_BYTES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            up_req,
  input logic            up_we,
  input logic            up_ack,
  input logic            nr_rd,
  input logic            nr_wr,
  input logic [NA_W-1:0] nr_addr,
  input logic            at_we
);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nr_rd && nr_wr));

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |=> !up_ack);

  // R4
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |-> $past(up_req));

  // R4
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |-> !(nr_rd || nr_wr));

  // R6
  bus_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_rd || nr_wr) |-> (int'(nr_addr) < NUM_REGS) &&
      !(int'(nr_addr) >= ATOM_BASE && int'(nr_addr) < ATOM_BASE + ATOM_BYTES));

  // R8
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_we |=> !at_we);

  // R8
  commit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_we |-> $past(up_req && up_we));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_req |-> !(nr_rd || nr_wr));

endmodule

bind reg_bridge reg_bridge_chk #(
  .NA_W(NA_W), .NUM_REGS(NUM_REGS), .ATOM_BASE(ATOM_BASE), .ATOM_BYTES(ATOM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_ack(up_ack),
  .nr_rd(nr_rd), .nr_wr(nr_wr), .nr_addr(nr_addr), .at_we(at_we)
);

// File: tb/reg_bridge_tb.sv
`timescale 1ns/1ps
module reg_bridge_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // packed-layout instance
  logic        d_req = 0, d_we = 0;
  logic [15:0] d_addr = '0;
  logic [3:0]  d_sel = '0;
  logic [31:0] d_wdata = '0, d_rdata;
  logic        d_ack, d_nr_rd, d_nr_wr, d_at_we;
  logic [5:0]  d_nr_addr;
  logic [7:0]  d_nr_wdata, d_nr_rdata = '0;
  logic [31:0] d_at_wdata, at_d = '0;
  logic [7:0]  mem_d [0:63];
  int          d_txn = 0, d_wes = 0, d_acks = 0;
  logic [5:0]  d_log [0:3];

  // spread-layout instance
  logic        s_req = 0, s_we = 0;
  logic [15:0] s_addr = '0;
  logic [3:0]  s_sel = '0;
  logic [31:0] s_wdata = '0, s_rdata;
  logic        s_ack, s_nr_rd, s_nr_wr, s_at_we;
  logic [5:0]  s_nr_addr;
  logic [7:0]  s_nr_wdata, s_nr_rdata = '0;
  logic [31:0] s_at_wdata, at_s = '0;
  logic [7:0]  mem_s [0:63];
  int          s_txn = 0, s_wes = 0, s_acks = 0;

  reg_bridge #(.SPARSE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_req(d_req), .up_we(d_we), .up_addr(d_addr),
    .up_sel(d_sel), .up_wdata(d_wdata), .up_ack(d_ack), .up_rdata(d_rdata),
    .nr_rd(d_nr_rd), .nr_wr(d_nr_wr), .nr_addr(d_nr_addr), .nr_wdata(d_nr_wdata),
    .nr_rdata(d_nr_rdata), .at_rdata(at_d), .at_we(d_at_we), .at_wdata(d_at_wdata));

  reg_bridge #(.SPARSE(1'b1)) u_dut_sp (
    .clk(clk), .rst_n(rst_n), .up_req(s_req), .up_we(s_we), .up_addr(s_addr),
    .up_sel(s_sel), .up_wdata(s_wdata), .up_ack(s_ack), .up_rdata(s_rdata),
    .nr_rd(s_nr_rd), .nr_wr(s_nr_wr), .nr_addr(s_nr_addr), .nr_wdata(s_nr_wdata),
    .nr_rdata(s_nr_rdata), .at_rdata(at_s), .at_we(s_at_we), .at_wdata(s_at_wdata));

  always @(posedge clk) begin
    if (d_nr_wr) mem_d[d_nr_addr] <= d_nr_wdata;
    if (d_nr_rd) d_nr_rdata <= mem_d[d_nr_addr];
    if (d_nr_rd || d_nr_wr) begin
      d_log[d_txn[1:0]] <= d_nr_addr;
      d_txn <= d_txn + 1;
    end
    if (d_at_we) begin at_d <= d_at_wdata; d_wes <= d_wes + 1; end
    if (d_ack) d_acks <= d_acks + 1;
    if (s_nr_wr) mem_s[s_nr_addr] <= s_nr_wdata;
    if (s_nr_rd) s_nr_rdata <= mem_s[s_nr_addr];
    if (s_nr_rd || s_nr_wr) s_txn <= s_txn + 1;
    if (s_at_we) begin at_s <= s_at_wdata; s_wes <= s_wes + 1; end
    if (s_ack) s_acks <= s_acks + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    d_txn = 0; d_wes = 0; d_acks = 0;
    s_txn = 0; s_wes = 0; s_acks = 0;
  endtask

  task automatic xfer(input bit sp, input bit we, input logic [15:0] a, input logic [3:0] sel,
                      input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    clear_counts();
    if (sp) begin s_req = 1; s_we = we; s_addr = a; s_sel = sel; s_wdata = wd; end
    else    begin d_req = 1; d_we = we; d_addr = a; d_sel = sel; d_wdata = wd; end
    waits = 0;
    forever begin
      @(negedge clk);
      waits++;
      if (sp ? s_ack : d_ack) break;
    end
    rd = sp ? s_rdata : d_rdata;
    if (sp) s_req = 0; else d_req = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 ack", {31'b0, d_ack | s_ack}, 32'd0);
    check("R10 strobes", {30'b0, d_nr_rd | d_nr_wr, s_nr_rd | s_nr_wr}, 32'd0);
    check("R10 at_we", {30'b0, d_at_we, s_at_we}, 32'd0);
  endtask

  task automatic t_dense_full();
    logic [31:0] rd; int w;
    xfer(0, 1, 16'h0004, 4'hF, 32'h44332211, rd, w);
    check("R2 lane0", {24'b0, mem_d[4]}, 32'h11);
    check("R2 lane3", {24'b0, mem_d[7]}, 32'h44);
    check("R3 count", d_txn, 32'd4);
    check("R3 order", {8'b0, 2'b0, d_log[0], 2'b0, d_log[1], 2'b0, d_log[3]}, {8'b0, 8'd4, 8'd5, 8'd7});
    check("R4 dense latency", w, 32'd5);
    check("R4 one ack", d_acks, 32'd1);
    xfer(0, 0, 16'h0004, 4'hF, 32'h0, rd, w);
    check("R2 read", rd, 32'h44332211);
  endtask

  task automatic t_dense_partial();
    logic [31:0] rd; int w;
    xfer(0, 1, 16'h0004, 4'b0101, 32'h99887766, rd, w);
    check("R3 sel lanes", {mem_d[7], mem_d[6], mem_d[5], mem_d[4]}, 32'h44882266);
    check("R3 sel count", d_txn, 32'd2);
    check("R3 sel order", {26'b0, d_log[1]}, 32'd6);
    xfer(0, 0, 16'h0004, 4'b0010, 32'h0, rd, w);
    check("R3 unselected zero", rd, 32'h00002200);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; int w;
    xfer(0, 1, 16'h0040, 4'hF, 32'hFFFFFFFF, rd, w);
    check("R6 no write txn", d_txn, 32'd0);
    xfer(0, 0, 16'h0040, 4'hF, 32'h0, rd, w);
    check("R6 read zero", rd, 32'h0);
    check("R6 acked", w, 32'd5);
    xfer(1, 0, 16'h0100, 4'h0, 32'h0, rd, w);
    check("R6 sparse zero", rd, 32'h0);
    check("R6 sparse no txn", s_txn, 32'd0);
  endtask

  task automatic t_dense_atomic();
    logic [31:0] rd; int w;
    xfer(0, 1, 16'h0008, 4'hF, 32'hDEADBEEF, rd, w);
    check("R8 whole word", at_d, 32'hDEADBEEF);
    check("R8 one update", d_wes, 32'd1);
    check("R8 no bus txn", d_txn, 32'd0);
    xfer(0, 0, 16'h0008, 4'hF, 32'h0, rd, w);
    check("R7 dense read", rd, 32'hDEADBEEF);
  endtask

  task automatic t_sparse_map();
    logic [31:0] rd; int w;
    xfer(1, 1, 16'h0014, 4'h0, 32'hFFFFFF5A, rd, w);
    check("R1 narrow byte", {24'b0, mem_s[5]}, 32'h5A);
    check("R1 one txn", s_txn, 32'd1);
    check("R4 sparse latency", w, 32'd2);
    mem_s[5] = 8'hC3;
    xfer(1, 0, 16'h0014, 4'h0, 32'h0, rd, w);
    check("R1 R5 read low byte", rd, 32'h000000C3);
    check("R4 sparse one ack", s_acks, 32'd1);
  endtask

  task automatic t_shadow_read();
    logic [31:0] rd; int w;
    at_s = 32'h11223344;
    xfer(1, 0, 16'h0020, 4'h0, 32'h0, rd, w);
    check("R7 byte0", rd, 32'h44);
    at_s = 32'h55667788;
    xfer(1, 0, 16'h0024, 4'h0, 32'h0, rd, w);
    check("R7 byte1 shadow", rd, 32'h33);
    xfer(1, 0, 16'h0028, 4'h0, 32'h0, rd, w);
    check("R7 byte2 shadow", rd, 32'h22);
    xfer(1, 0, 16'h002C, 4'h0, 32'h0, rd, w);
    check("R7 byte3 shadow", rd, 32'h11);
  endtask

  task automatic t_broken_read();
    logic [31:0] rd; int w;
    at_s = 32'h11223344;
    xfer(1, 0, 16'h0020, 4'h0, 32'h0, rd, w);
    xfer(1, 0, 16'h0000, 4'h0, 32'h0, rd, w);
    at_s = 32'hAABBCCDD;
    xfer(1, 0, 16'h0024, 4'h0, 32'h0, rd, w);
    check("R9 live after break", rd, 32'hCC);
  endtask

  task automatic t_write_seq();
    logic [31:0] rd; int w; int wes = 0;
    at_s = 32'h0;
    xfer(1, 1, 16'h0020, 4'h0, 32'h01, rd, w); wes += s_wes;
    xfer(1, 1, 16'h0024, 4'h0, 32'h02, rd, w); wes += s_wes;
    xfer(1, 1, 16'h0028, 4'h0, 32'h03, rd, w); wes += s_wes;
    check("R8 held in shadow", at_s, 32'h0);
    check("R8 no early update", wes, 32'd0);
    xfer(1, 1, 16'h002C, 4'h0, 32'h04, rd, w);
    check("R8 committed", at_s, 32'h04030201);
    check("R8 single update", s_wes, 32'd1);
  endtask

  task automatic t_broken_write();
    logic [31:0] rd; int w;
    xfer(1, 1, 16'h0020, 4'h0, 32'hA0, rd, w);
    xfer(1, 1, 16'h0024, 4'h0, 32'hA1, rd, w);
    xfer(1, 0, 16'h0000, 4'h0, 32'h0, rd, w);
    xfer(1, 1, 16'h0028, 4'h0, 32'hA2, rd, w);
    xfer(1, 1, 16'h002C, 4'h0, 32'hA3, rd, w);
    check("R9 top write ignored", at_s, 32'h04030201);
    check("R9 no update", s_wes, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem_d[i] = 8'h00; mem_s[i] = 8'h00; end
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dense_full();
    t_dense_partial();
    t_unmapped();
    t_dense_atomic();
    t_sparse_map();
    t_shadow_read();
    t_broken_read();
    t_write_seq();
    t_broken_write();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule